// File: doc/BRIEF.md
# Square-Array Static Memory, 1K x 4

This block is a synchronous model of a static memory that holds 1024 words of 4 bits. The cells are not laid out as 1024 short rows. They form a square of 64 rows, each 64 bits wide. The upper part of the address picks one word line, which opens a whole 64-bit row. The lower part of the address drives four 16-to-1 column selectors, one for each data bit, and these pick the 4 bits of the addressed word out of that row.

Writes are done as a read-modify-write of the open row. Only the four bit positions of the addressed column are replaced, and the other 60 bits of the row are written back as they were. Reads are registered. The decoded word lines are brought out on a debug port, so the row decode can be observed directly.

Top module: `sram_rc_top`

## Requirements
- R1: Each of the 1024 addresses holds its own 4-bit value. Writing one address never changes what another address reads back.
- R2: During an enabled access, exactly one bit of the 64-bit word-line output is high. That bit is the one at index addr[9:4].
- R3: A write replaces only the addressed column, addr[3:0], in its row. The other 15 words that share the row keep their contents.
- R4: With chip enable low, the memory contents do not change, whatever the values of read/not-write, address and data in.
- R5: With chip enable high and read/not-write high, the addressed word appears on data out one clock after the request.
- R6: Data out keeps its last value through write cycles and through cycles with chip enable low.
- R7: While reset is asserted, data out is 0.
- R8: With chip enable low, all 64 word lines are low.
- R9: Data bit k of a word is stored at row bit position k*16 + addr[3:0]. This mapping holds for all four bits, so every data bit is kept apart from the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high; clears data out |
| ce | input | 1 | Chip enable; low means no operation |
| rnw | input | 1 | Operation select: 1 reads, 0 writes |
| addr | input | 10 | Word address: [9:4] row, [3:0] column |
| din | input | 4 | Write data |
| dout | output | 4 | Registered read data |
| wordLineDbg | output | 64 | One-hot word-line decode, all zero when idle |

## Verification
The bench fills every address with a pattern computed from the address, in which each data bit depends on the address in its own way. It then reads all of them back. A wrong row/column split or a broken column selector would show up as aliased words. A bit-lane mix-up would show up as swapped bits.

The bench then rewrites a single column and sweeps the rest of that row. This catches a write that stores the full row from the write data instead of merging it, since such a write would wipe the neighbouring words.

Finally, the bench drives writes and reads with chip enable low, using data that differs from what is stored. A design that ignores chip enable would show this as corrupted contents or as a changed data out. The bench also samples data out just before and just after the clock edge, which exposes a read path with the wrong latency.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;
  // Strobes from control to datapath, one per operation kind
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/sram_rc_ctrl.sv
module sram_rc_ctrl
  import sram_rc_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4
) (
  input  logic                         ce,
  input  logic                         rnw,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  output ctrlStrobes_t                 strb,
  output logic [ROW_BITS-1:0]          rowAddr,
  output logic [COL_BITS-1:0]          colAddr
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;

  // Operation decode: chip enable gates both strobes
  always_comb begin
    strb.rdEn = ce & rnw;
    strb.wrEn = ce & ~rnw;
  end

  // Upper bits pick the row, lower bits pick the column group
  assign rowAddr = addr[ADDR_W-1:COL_BITS];
  assign colAddr = addr[COL_BITS-1:0];
endmodule

// File: rtl/sram_rc_datapath.sv
module sram_rc_datapath
  import sram_rc_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrlStrobes_t                strb,
  input  logic [ROW_BITS-1:0]         rowAddr,
  input  logic [COL_BITS-1:0]         colAddr,
  input  logic [DATA_W-1:0]           din,
  output logic [DATA_W-1:0]           dout,
  output logic [(1<<ROW_BITS)-1:0]    wordLine
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int COLS  = 1 << COL_BITS;
  localparam int ROW_W = DATA_W * COLS;
  localparam int IDX_W = $clog2(ROW_W);

  logic [ROW_W-1:0]  cells [ROWS];
  logic [ROW_W-1:0]  selRow;
  logic [ROW_W-1:0]  mergedRow;
  logic [DATA_W-1:0] colBits;
  logic              access;

  assign access = strb.rdEn | strb.wrEn;

  // Row decoder: one comparator per word line
  for (genvar r = 0; r < ROWS; r++) begin : g_wordLine
    assign wordLine[r] = access && (rowAddr == ROW_BITS'(r));
  end

  // Row sensing: the active word line puts its row on the bit lines
  always_comb begin
    selRow = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (wordLine[r]) selRow = selRow | cells[r];
    end
  end

  // Column selection: one COLS-to-1 selector per data bit
  for (genvar k = 0; k < DATA_W; k++) begin : g_colMux
    logic [IDX_W-1:0] bitIdx;
    assign bitIdx     = IDX_W'(k * COLS) + IDX_W'(colAddr);
    assign colBits[k] = selRow[bitIdx];
  end

  // Read-modify-write: replace only the addressed column group
  always_comb begin
    mergedRow = selRow;
    for (int k = 0; k < DATA_W; k++) begin
      mergedRow[IDX_W'(k * COLS) + IDX_W'(colAddr)] = din[k];
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (wordLine[r] && strb.wrEn) cells[r] <= mergedRow;
    end
  end

  // Registered read data, held while no read happens
  always_ff @(posedge clk or posedge rst) begin
    if (rst)            dout <= '0;
    else if (strb.rdEn) dout <= colBits;
  end
endmodule

// File: rtl/sram_rc_top.sv
module sram_rc_top
  import sram_rc_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ce,
  input  logic                         rnw,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic [DATA_W-1:0]            din,
  output logic [DATA_W-1:0]            dout,
  output logic [(1<<ROW_BITS)-1:0]     wordLineDbg
);
  ctrlStrobes_t        strb;
  logic [ROW_BITS-1:0] rowAddr;
  logic [COL_BITS-1:0] colAddr;

  sram_rc_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_ctrl (
    .ce(ce), .rnw(rnw), .addr(addr),
    .strb(strb), .rowAddr(rowAddr), .colAddr(colAddr)
  );

  sram_rc_datapath #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .rowAddr(rowAddr), .colAddr(colAddr),
    .din(din), .dout(dout), .wordLine(wordLineDbg)
  );
endmodule

// File: rtl/sram_rc_checker.sv
module sram_rc_checker #(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         ce,
  input logic                         rnw,
  input logic [ROW_BITS+COL_BITS-1:0] addr,
  input logic [DATA_W-1:0]            din,
  input logic [DATA_W-1:0]            dout,
  input logic [(1<<ROW_BITS)-1:0]     wordLineDbg
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;

  // R2: exactly one word line during an enabled access
  a_r2_one_line: assert property (@(posedge clk) disable iff (rst)
    ce |-> $countones(wordLineDbg) == 1);

  // R2: the active line is the one named by the row address
  a_r2_line_match: assert property (@(posedge clk) disable iff (rst)
    ce |-> wordLineDbg[addr[ADDR_W-1:COL_BITS]]);

  // R8: no word line while chip enable is low
  a_r8_idle_lines: assert property (@(posedge clk) disable iff (rst)
    !ce |-> wordLineDbg == '0);

  // R6: data out is held when no read is requested
  a_r6_dout_hold: assert property (@(posedge clk) disable iff (rst)
    !(ce && rnw) |=> $stable(dout));

  // R5: a read right after a write to the same address returns the written data
  a_r5_read_after_write: assert property (@(posedge clk) disable iff (rst)
    (ce && rnw && $past(ce && !rnw) && addr == $past(addr)) |=> dout == $past(din, 2));

  // R7: data out cleared during reset
  always @(negedge clk) begin
    if (rst) a_r7_reset_dout: assert (dout == '0);
  end
endmodule

bind sram_rc_top sram_rc_checker #(
  .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)
) i_sram_rc_checker (
  .clk(clk), .rst(rst), .ce(ce), .rnw(rnw), .addr(addr),
  .din(din), .dout(dout), .wordLineDbg(wordLineDbg)
);

// File: tb/test_sram_rc_top.sv
module test_sram_rc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ce;
  logic        rnw;
  logic [9:0]  addr;
  logic [3:0]  din;
  logic [3:0]  dout;
  logic [63:0] wordLineDbg;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sram_rc_top i_sram_rc_top (
    .clk(clk), .rst(rst), .ce(ce), .rnw(rnw), .addr(addr),
    .din(din), .dout(dout), .wordLineDbg(wordLineDbg)
  );

  // Pattern per address; each data bit depends on the address differently
  function automatic logic [3:0] pat(input logic [9:0] a);
    logic [9:0] m;
    m = a * 10'd7 + (a >> 4) + (a >> 7);
    return m[3:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one write; returns at the next falling edge
  task automatic doWrite(input logic [9:0] a, input logic [3:0] d, input bit chkLine);
    ce = 1'b1; rnw = 1'b0; addr = a; din = d;
    #1;
    if (chkLine) check("R2 write line", wordLineDbg, 64'd1 << a[9:4]);
    @(negedge clk);
    ce = 1'b0;
  endtask

  // Drive one read and check the word one clock later
  task automatic doRead(input logic [9:0] a, input logic [3:0] exp, input string req);
    ce = 1'b1; rnw = 1'b1; addr = a; din = 4'h0;
    #1;
    check("R2 read line", wordLineDbg, 64'd1 << a[9:4]);
    @(negedge clk);
    ce = 1'b0;
    check(req, {60'd0, dout}, {60'd0, exp});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] held;
    logic [9:0] tgt;
    rst = 1'b1; ce = 1'b0; rnw = 1'b1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    check("R7 reset dout", {60'd0, dout}, 64'd0);
    check("R8 idle lines", wordLineDbg, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R9: fill every address, then read all back
    for (int a = 0; a < 1024; a++) doWrite(10'(a), pat(10'(a)), (a % 61) == 0);
    for (int a = 0; a < 1024; a++) doRead(10'(a), pat(10'(a)), "R1 R9 sweep");

    // R3: rewrite one column, neighbours in that row unchanged
    tgt = {6'd37, 4'd9};
    doWrite(tgt, ~pat(tgt), 1'b1);
    for (int c = 0; c < 16; c++) begin
      logic [9:0] a2;
      a2 = {6'd37, 4'(c)};
      doRead(a2, (c == 9) ? ~pat(a2) : pat(a2), "R3 row merge");
    end
    doRead({6'd36, 4'd9}, pat({6'd36, 4'd9}), "R3 other row");

    // R5: data out changes only after the clock edge
    doRead(10'd0, pat(10'd0), "R5 prior");
    ce = 1'b1; rnw = 1'b1; addr = 10'd1023;
    @(posedge clk); #0.5;
    check("R5 before edge+", {60'd0, dout}, {60'd0, pat(10'd1023)});
    @(negedge clk); ce = 1'b0;
    doRead(10'd0, pat(10'd0), "R5 prior2");
    ce = 1'b1; rnw = 1'b1; addr = 10'd1023;
    #2;
    check("R5 before edge", {60'd0, dout}, {60'd0, pat(10'd0)});
    @(negedge clk); ce = 1'b0;
    check("R5 after edge", {60'd0, dout}, {60'd0, pat(10'd1023)});

    // R6: write and idle cycles leave dout as it was
    held = pat(10'd1023);
    doWrite(10'd500, 4'h5, 1'b0);
    check("R6 hold after write", {60'd0, dout}, {60'd0, held});
    @(negedge clk);
    check("R6 hold when idle", {60'd0, dout}, {60'd0, held});

    // R4 / R8: disabled write and read do nothing
    ce = 1'b0; rnw = 1'b0; addr = 10'd200; din = ~pat(10'd200);
    #1;
    check("R8 disabled lines", wordLineDbg, 64'd0);
    @(negedge clk);
    rnw = 1'b1; addr = 10'd777;
    @(negedge clk);
    check("R4 disabled read dout", {60'd0, dout}, {60'd0, held});
    doRead(10'd200, pat(10'd200), "R4 contents kept");
    doRead(10'd500, 4'h5, "R1 rewrite");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule